// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer

This block is one processor's counter/timer. It works in one of two modes, chosen by an external mode bit. In counter mode it is a limit-match timer. A count advances by one unit on each tick. When the count would reach a programmed limit, it returns to zero, sets a reached flag and raises an interrupt. A zero limit makes the counter run freely, with no match. In user mode the same word-indexed registers become a 63-bit count, split into a high word and a low word. Software can load both words, start and stop the count through a status register, and read it back. The interrupt is held low in this mode.

All values are in register units. Bits 8..0 of every count are always zero, so one tick adds 0x200. Register reads are combinational while `rd_en` is high. Read side effects and all writes take effect at the rising clock edge. A change of the mode input is detected against its registered copy. The actions tied to the change happen on the edge where the change is first seen.

Top module: `dual_mode_cpu_timer`

## Requirements
- R1: After reset the block is in counter mode with the run bit set, count 0, reached flag 0, limit 0 (free-run) and the interrupt low.
- R2: In counter mode the count advances by 0x200 on every tick, whatever the run bit holds. Index 1 reads {reached, count[30:0]} with bits 8..0 zero. A write to index 1 has no effect.
- R3: In counter mode a write to index 0 stores bits 30..9 as the limit, clears the count and lowers the interrupt. On the tick where the count would equal a non-zero limit, the count returns to 0 and the reached flag (bit 31) and the interrupt are set.
- R4: In counter mode a read of index 0 returns the limit with bit 31 clear. At that edge it clears the reached flag and the interrupt.
- R5: In counter mode with a zero limit the count advances freely and never sets the reached flag or the interrupt.
- R6: In user mode index 0 reads {reached, count[62:32]} and index 1 reads count[31:0]. A read of index 0 latches the low word, and the next read of index 1 returns that latched value rather than the live one.
- R7: In user mode a write to index 0 loads count[62:32] from data bits 30..0. A write to index 1 loads count[31:9] from data bits 31..9. Either write clears the reached flag.
- R8: In user mode with the run bit set, the count advances 0x200 per tick. On the tick where it would reach 0x7FFFFFFFFFFFFE00 it returns to 0 and sets the reached flag. The interrupt is never raised in user mode.
- R9: Writing index 3 stores data bit 0 as the run bit, and reading index 3 returns it in bit 0. In user mode a clear run bit holds the count still.
- R10: On the edge where the mode input is first seen high, the interrupt is lowered and the count keeps its value. From then on the count advances only if the run bit is set.
- R11: On the edge where the mode input is first seen low again, the count is cleared. Counting then resumes on every tick regardless of the run bit.
- R12: A register write that changes the count takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count enable pulse, one unit per cycle it is high |
| user_mode | input | 1 | 1 selects the 63-bit user counter, 0 the limit-match counter |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (enables read side effects) |
| addr | input | 2 | Word index of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Limit-match interrupt (counter mode only) |

## Verification
Most internal faults show up at the ports within one register read. A wrong count, snapshot or reached value appears in the next read of index 0 or 1. A wrong run bit appears in the next read of index 3. Faults in the mode-transition logic take longer to surface. A missed interrupt clear or count clear on a mode change shows on `irq` one cycle after the transition edge, or in the first count read after it. A faulty terminal compare stays hidden until the count crosses its limit, so the loads place the count two ticks below the 63-bit terminal value.

// File: rtl/tmr_pkg.sv
// Package: shared constants and register index type for the dual-mode timer.
// Assumes a 32-bit register word; the fractional low bits are fixed zero.
package tmr_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        IDX_LIMIT_HI = 2'd0,
        IDX_COUNT_LO = 2'd1,
        IDX_SPARE    = 2'd2,
        IDX_STATUS   = 2'd3
    } reg_idx_e;
endpackage

// File: rtl/tmr_count_core.sv
// Module: count register in tick units with a terminal compare.
// Assumes clear has priority over load, and load over a tick advance.
// The count wraps to zero on the tick whose next value equals term.
module tmr_count_core #(
    parameter int UNITS_W = 54
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               load_en,
    input  logic [UNITS_W-1:0] load_val,
    input  logic               advance,
    input  logic [UNITS_W-1:0] term,
    output logic [UNITS_W-1:0] count,
    output logic               wrap
);
    logic [UNITS_W-1:0] next_cnt;

    // Next value and terminal detection
    always_comb begin
        next_cnt = count + UNITS_W'(1);
        wrap     = advance && !clear && !load_en && (next_cnt == term);
    end

    // Count register update
    always_ff @(posedge clk) begin
        if (!rst_n)       count <= '0;
        else if (clear)   count <= '0;
        else if (load_en) count <= load_val;
        else if (advance) count <= wrap ? '0 : next_cnt;
    end
endmodule

// File: rtl/tmr_mode_ctl.sv
// Module: registers the mode input and flags its transitions.
// Assumes the mode input is synchronous to clk; reset takes counter mode.
module tmr_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic user_mode,
    output logic mode_q,
    output logic enter_user,
    output logic leave_user
);
    // Transition detection against the registered mode
    always_comb begin
        enter_user = user_mode && !mode_q;
        leave_user = !user_mode && mode_q;
    end

    // Registered copy of the mode input
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= user_mode;
    end
endmodule

// File: rtl/tmr_read_mux.sv
// Module: read data selection for the dual-mode timer registers.
// Assumes CTR_W = HI_W - FRAC_W and LO_W = WORD_W - FRAC_W.
// Purely combinational; all side effects live in the top.
module tmr_read_mux
    import tmr_pkg::*;
#(
    parameter int FRAC_W  = 9,
    parameter int HI_W    = 31,
    parameter int LO_W    = 23,
    parameter int UNITS_W = 54,
    parameter int CTR_W   = 22
) (
    input  logic               user_mode,
    input  logic [1:0]         addr,
    input  logic [UNITS_W-1:0] count,
    input  logic [CTR_W-1:0]   limit_units,
    input  logic               reached,
    input  logic               run,
    input  logic [WORD_W-1:0]  lo_snap,
    input  logic               snap_valid,
    output logic [WORD_W-1:0]  lo_live,
    output logic [WORD_W-1:0]  rdata
);
    logic [WORD_W-1:0] hi_word;
    logic [WORD_W-1:0] ctr_word;
    logic [WORD_W-1:0] lim_word;
    reg_idx_e          idx;

    // Word views of the count, limit and status
    always_comb begin
        idx      = reg_idx_e'(addr);
        hi_word  = {reached, count[UNITS_W-1 -: HI_W]};
        lo_live  = {count[LO_W-1:0], {FRAC_W{1'b0}}};
        ctr_word = {reached, count[CTR_W-1:0], {FRAC_W{1'b0}}};
        lim_word = {1'b0, limit_units, {FRAC_W{1'b0}}};
    end

    // Mode-dependent register selection
    always_comb begin
        case (idx)
            IDX_LIMIT_HI: rdata = user_mode ? hi_word : lim_word;
            IDX_COUNT_LO: rdata = user_mode ? (snap_valid ? lo_snap : lo_live) : ctr_word;
            IDX_STATUS:   rdata = {{(WORD_W-1){1'b0}}, run};
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/dual_mode_cpu_timer.sv
// Module: per-processor counter/timer with a limit-match mode and a
// 63-bit user counter mode selected by user_mode.
// Assumes single-cycle register strobes, never rd_en and wr_en together,
// and a synchronous active-low reset.
module dual_mode_cpu_timer
    import tmr_pkg::*;
#(
    parameter int FRAC_W = 9,
    parameter int HI_W   = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              user_mode,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              irq
);
    localparam int LO_W    = WORD_W - FRAC_W;
    localparam int UNITS_W = HI_W + LO_W;
    localparam int CTR_W   = HI_W - FRAC_W;

    logic               mode_q, enter_user, leave_user;
    logic [UNITS_W-1:0] count_q, load_val, term;
    logic               wrap, clear, user_load, advance;
    logic               wr_hi, wr_lo, wr_st, rd_hi, rd_lo, ctr_lim_wr;
    logic [CTR_W-1:0]   limit_q;
    logic               run_q, reached_q, irq_q, snap_valid_q, match_en;
    logic [WORD_W-1:0]  lo_snap_q, lo_live;

    // Register strobe decode
    always_comb begin
        wr_hi      = wr_en && (addr == IDX_LIMIT_HI);
        wr_lo      = wr_en && (addr == IDX_COUNT_LO);
        wr_st      = wr_en && (addr == IDX_STATUS);
        rd_hi      = rd_en && (addr == IDX_LIMIT_HI);
        rd_lo      = rd_en && (addr == IDX_COUNT_LO);
        ctr_lim_wr = wr_hi && !user_mode;
        user_load  = (wr_hi || wr_lo) && user_mode;
    end

    // Count control: load value, clear, advance gate and terminal
    always_comb begin
        if (wr_hi) load_val = {wdata[HI_W-1:0], count_q[LO_W-1:0]};
        else       load_val = {count_q[UNITS_W-1:LO_W], wdata[WORD_W-1:FRAC_W]};
        clear    = leave_user || ctr_lim_wr;
        advance  = tick && (!user_mode || run_q);
        match_en = user_mode || (limit_q != '0);
        if (user_mode)             term = '1;
        else if (limit_q == '0)    term = UNITS_W'({CTR_W{1'b1}});
        else                       term = UNITS_W'(limit_q);
    end

    tmr_mode_ctl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .user_mode  (user_mode),
        .mode_q     (mode_q),
        .enter_user (enter_user),
        .leave_user (leave_user)
    );

    tmr_count_core #(.UNITS_W(UNITS_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .load_en  (user_load),
        .load_val (load_val),
        .advance  (advance),
        .term     (term),
        .count    (count_q),
        .wrap     (wrap)
    );

    tmr_read_mux #(
        .FRAC_W  (FRAC_W),
        .HI_W    (HI_W),
        .LO_W    (LO_W),
        .UNITS_W (UNITS_W),
        .CTR_W   (CTR_W)
    ) u_rmux (
        .user_mode   (user_mode),
        .addr        (addr),
        .count       (count_q),
        .limit_units (limit_q),
        .reached     (reached_q),
        .run         (run_q),
        .lo_snap     (lo_snap_q),
        .snap_valid  (snap_valid_q),
        .lo_live     (lo_live),
        .rdata       (rdata)
    );

    // Limit and run bit storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit_q <= '0;
            run_q   <= 1'b1;
        end else begin
            if (ctr_lim_wr) limit_q <= wdata[HI_W-1:FRAC_W];
            if (wr_st)      run_q   <= wdata[0];
        end
    end

    // Reached flag: set on a match, cleared by loads or a limit read
    always_ff @(posedge clk) begin
        if (!rst_n)                        reached_q <= 1'b0;
        else if (wrap && match_en)         reached_q <= 1'b1;
        else if (user_load)                reached_q <= 1'b0;
        else if (rd_hi && !user_mode)      reached_q <= 1'b0;
    end

    // Interrupt: raised only on a counter-mode limit match
    always_ff @(posedge clk) begin
        if (!rst_n)                                    irq_q <= 1'b0;
        else if (wrap && match_en && !user_mode)       irq_q <= 1'b1;
        else if (enter_user || ctr_lim_wr || (rd_hi && !user_mode))
                                                       irq_q <= 1'b0;
    end

    // Low-word snapshot taken by a user-mode high-word read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_snap_q    <= '0;
            snap_valid_q <= 1'b0;
        end else if (rd_hi && user_mode) begin
            lo_snap_q    <= lo_live;
            snap_valid_q <= 1'b1;
        end else if (rd_lo || user_load || enter_user || leave_user) begin
            snap_valid_q <= 1'b0;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/tmr_checker.sv
// Module: protocol and behaviour assertions for dual_mode_cpu_timer,
// attached with the bind below. Assumes the top's internal names.
module tmr_checker #(
    parameter int FRAC_W  = 9,
    parameter int UNITS_W = 54
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic               user_mode,
    input logic               wr_en,
    input logic               rd_en,
    input logic [1:0]         addr,
    input logic [31:0]        rdata,
    input logic               irq,
    input logic               run_q,
    input logic               mode_q,
    input logic [UNITS_W-1:0] count_q
);
    // R8: no interrupt while user mode has been held
    a_r8_no_irq_user: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && $past(user_mode)) |-> !irq);

    // R3: interrupt only rises after a counter-mode tick
    a_r3_irq_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(!user_mode && tick));

    // R4: a counter-mode limit read without a tick leaves irq low
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd0 && !user_mode && !tick && !wr_en) |=> !irq);

    // R9: a stopped user counter holds its value
    a_r9_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && mode_q && !run_q && !wr_en) |=> $stable(count_q));

    // R11: leaving user mode clears the count
    a_r11_leave_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!user_mode && mode_q) |=> (count_q == '0));

    // R2: low-word reads keep the fractional bits zero
    a_r2_frac_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd1) |-> (rdata[FRAC_W-1:0] == '0));
endmodule

bind dual_mode_cpu_timer tmr_checker #(
    .FRAC_W  (FRAC_W),
    .UNITS_W (UNITS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .user_mode (user_mode),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .rdata     (rdata),
    .irq       (irq),
    .run_q     (run_q),
    .mode_q    (mode_q),
    .count_q   (count_q)
);

// File: tb/dual_mode_cpu_timer_tb.sv
// Bench: vector table walked by one loop, then directed reset and corner tests.
module dual_mode_cpu_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        user_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = 32'd0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [1:0] OI = 2'd0;  // idle
    localparam logic [1:0] OW = 2'd1;  // write
    localparam logic [1:0] OR = 2'd2;  // read and compare

    // Entry: {req, tick, op, mode, addr, data, expected rdata, expected irq before edge}
    localparam int NV = 47;
    localparam logic [74:0] VEC [NV] = '{
        {4'd1,  1'b0, OR, 1'b0, 2'd3, 32'h0,        32'h1,        1'b0}, // R1 run set
        {4'd1,  1'b0, OR, 1'b0, 2'd1, 32'h0,        32'h0,        1'b0}, // R1 count zero
        {4'd3,  1'b0, OW, 1'b0, 2'd0, 32'h00000600, 32'h0,        1'b0}, // R3 limit 3 units
        {4'd2,  1'b1, OI, 1'b0, 2'd0, 32'h0,        32'h0,        1'b0}, // R2 tick
        {4'd2,  1'b1, OI, 1'b0, 2'd0, 32'h0,        32'h0,        1'b0}, // R2 tick
        {4'd2,  1'b0, OR, 1'b0, 2'd1, 32'h0,        32'h00000400, 1'b0}, // R2 count 0x400
        {4'd3,  1'b1, OI, 1'b0, 2'd0, 32'h0,        32'h0,        1'b0}, // R3 match tick
        {4'd3,  1'b0, OR, 1'b0, 2'd1, 32'h0,        32'h80000000, 1'b1}, // R3 reached, irq
        {4'd4,  1'b0, OR, 1'b0, 2'd0, 32'h0,        32'h00000600, 1'b1}, // R4 limit read
        {4'd4,  1'b0, OR, 1'b0, 2'd1, 32'h0,        32'h0,        1'b0}, // R4 cleared
        {4'd2,  1'b0, OW, 1'b0, 2'd1, 32'h12345600, 32'h0,        1'b0}, // R2 ignored write
        {4'd2,  1'b0, OR, 1'b0, 2'd1, 32'h0,        32'h0,        1'b0}, // R2 still zero
        {4'd3,  1'b1, OI, 1'b0, 2'd0, 32'h0,        32'h0,        1'b0}, // R3 tick
        {4'd3,  1'b1, OI, 1'b0, 2'd0, 32'h0,        32'h0,        1'b0}, // R3 tick
        {4'd3,  1'b1, OI, 1'b0, 2'd0, 32'h0,        32'h0,        1'b0}, // R3 match tick
        {4'd3,  1'b0, OI, 1'b0, 2'd0, 32'h0,        32'h0,        1'b1}, // R3 irq high
        {4'd10, 1'b0, OI, 1'b1, 2'd0, 32'h0,        32'h0,        1'b1}, // R10 enter user
        {4'd10, 1'b0, OR, 1'b1, 2'd3, 32'h0,        32'h1,        1'b0}, // R10 irq lowered
        {4'd6,  1'b0, OR, 1'b1, 2'd0, 32'h0,        32'h80000000, 1'b0}, // R6 high word
        {4'd8,  1'b1, OI, 1'b1, 2'd0, 32'h0,        32'h0,        1'b0}, // R8 tick
        {4'd6,  1'b0, OR, 1'b1, 2'd1, 32'h0,        32'h0,        1'b0}, // R6 latched low
        {4'd6,  1'b0, OR, 1'b1, 2'd1, 32'h0,        32'h00000200, 1'b0}, // R6 live low
        {4'd9,  1'b0, OW, 1'b1, 2'd3, 32'h0,        32'h0,        1'b0}, // R9 stop
        {4'd9,  1'b1, OI, 1'b1, 2'd0, 32'h0,        32'h0,        1'b0}, // R9 tick ignored
        {4'd9,  1'b0, OR, 1'b1, 2'd1, 32'h0,        32'h00000200, 1'b0}, // R9 held
        {4'd9,  1'b0, OR, 1'b1, 2'd3, 32'h0,        32'h0,        1'b0}, // R9 run clear
        {4'd7,  1'b0, OW, 1'b1, 2'd0, 32'hFFFFFFFF, 32'h0,        1'b0}, // R7 high load
        {4'd7,  1'b0, OW, 1'b1, 2'd1, 32'hFFFFFAFF, 32'h0,        1'b0}, // R7 low load
        {4'd7,  1'b0, OR, 1'b1, 2'd0, 32'h0,        32'h7FFFFFFF, 1'b0}, // R7 high masked
        {4'd7,  1'b0, OR, 1'b1, 2'd1, 32'h0,        32'hFFFFFA00, 1'b0}, // R7 low masked
        {4'd9,  1'b0, OW, 1'b1, 2'd3, 32'h1,        32'h0,        1'b0}, // R9 start
        {4'd8,  1'b1, OI, 1'b1, 2'd0, 32'h0,        32'h0,        1'b0}, // R8 tick
        {4'd8,  1'b1, OI, 1'b1, 2'd0, 32'h0,        32'h0,        1'b0}, // R8 terminal tick
        {4'd8,  1'b0, OI, 1'b1, 2'd0, 32'h0,        32'h0,        1'b0}, // R8 no irq
        {4'd8,  1'b0, OR, 1'b1, 2'd0, 32'h0,        32'h80000000, 1'b0}, // R8 wrapped, reached
        {4'd8,  1'b0, OR, 1'b1, 2'd1, 32'h0,        32'h0,        1'b0}, // R8 low zero
        {4'd9,  1'b0, OW, 1'b1, 2'd3, 32'h0,        32'h0,        1'b0}, // R9 stop
        {4'd11, 1'b0, OI, 1'b0, 2'd0, 32'h0,        32'h0,        1'b0}, // R11 leave user
        {4'd11, 1'b1, OI, 1'b0, 2'd0, 32'h0,        32'h0,        1'b0}, // R11 tick, run clear
        {4'd11, 1'b0, OR, 1'b0, 2'd1, 32'h0,        32'h80000200, 1'b0}, // R11 counted
        {4'd9,  1'b0, OR, 1'b0, 2'd3, 32'h0,        32'h0,        1'b0}, // R9 run kept
        {4'd5,  1'b0, OW, 1'b0, 2'd0, 32'h0,        32'h0,        1'b0}, // R5 zero limit
        {4'd5,  1'b0, OR, 1'b0, 2'd0, 32'h0,        32'h0,        1'b0}, // R5 limit reads 0
        {4'd5,  1'b0, OR, 1'b0, 2'd1, 32'h0,        32'h0,        1'b0}, // R5 count 0
        {4'd5,  1'b1, OI, 1'b0, 2'd0, 32'h0,        32'h0,        1'b0}, // R5 tick
        {4'd5,  1'b1, OI, 1'b0, 2'd0, 32'h0,        32'h0,        1'b0}, // R5 tick
        {4'd5,  1'b0, OR, 1'b0, 2'd1, 32'h0,        32'h00000400, 1'b0}  // R5 free count
    };

    dual_mode_cpu_timer u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .user_mode (user_mode),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .irq       (irq)
    );

    always #4 clk = ~clk;

    // Drive one cycle at the falling edge, compare just before the rising edge
    task automatic apply(input int req, input logic tk, input logic [1:0] op,
                         input logic md, input logic [1:0] ad, input logic [31:0] d,
                         input logic [31:0] exp_rd, input logic exp_irq);
        @(negedge clk);
        tick      = tk;
        user_mode = md;
        wr_en     = (op == OW);
        rd_en     = (op == OR);
        addr      = ad;
        wdata     = d;
        #3;
        if (op == OR) begin
            checks++;
            if (rdata !== exp_rd) begin
                fails++;
                $display("FAIL R%0d: rdata idx %0d actual %h expected %h", req, ad, rdata, exp_rd);
            end
        end
        checks++;
        if (irq !== exp_irq) begin
            fails++;
            $display("FAIL R%0d: irq actual %b expected %b", req, irq, exp_irq);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; rd_en = 1'b0; user_mode = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        for (int i = 0; i < NV; i++) begin
            apply(int'(VEC[i][74:71]), VEC[i][70], VEC[i][69:68], VEC[i][67],
                  VEC[i][66:65], VEC[i][64:33], VEC[i][32:1], VEC[i][0]);
        end

        // R1: reset in the middle of activity restores the reset state
        apply(1, 1'b1, OW, 1'b0, 2'd3, 32'h0, 32'h0, 1'b0);
        do_reset();
        apply(1, 1'b0, OR, 1'b0, 2'd3, 32'h0, 32'h1, 1'b0);
        apply(1, 1'b0, OR, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0);
        apply(1, 1'b0, OR, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0);

        // R9: counter mode counts with the run bit clear
        apply(9, 1'b0, OW, 1'b0, 2'd3, 32'h0, 32'h0, 1'b0);
        apply(9, 1'b1, OI, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0);
        apply(9, 1'b0, OR, 1'b0, 2'd1, 32'h0, 32'h00000200, 1'b0);
        // R10: entering user mode with run clear keeps and holds the count
        apply(10, 1'b0, OI, 1'b1, 2'd0, 32'h0, 32'h0, 1'b0);
        apply(10, 1'b1, OI, 1'b1, 2'd0, 32'h0, 32'h0, 1'b0);
        apply(10, 1'b0, OR, 1'b1, 2'd1, 32'h0, 32'h00000200, 1'b0);
        // R12: a low-word load wins over a tick in the same cycle
        apply(12, 1'b0, OW, 1'b1, 2'd3, 32'h1, 32'h0, 1'b0);
        apply(12, 1'b1, OW, 1'b1, 2'd1, 32'h00000800, 32'h0, 1'b0);
        apply(12, 1'b0, OR, 1'b1, 2'd1, 32'h0, 32'h00000800, 1'b0);
        // R11: returning to counter mode clears the count at once
        apply(11, 1'b0, OI, 1'b0, 2'd0, 32'h0, 32'h0, 1'b0);
        apply(11, 1'b0, OR, 1'b0, 2'd1, 32'h0, 32'h0, 1'b0);
        apply(9, 1'b0, OR, 1'b0, 2'd3, 32'h0, 32'h1, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is reported as a failed check
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1: watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule